// File: doc/BRIEF.md
# Peak Energy Window Locator

This block takes an effective impulse response (the cascade of a channel and its shortening filter), delivered one signed tap per cycle. It finds the start position Δ of the `WIN_LEN`-tap window that holds the most energy. Energy here means the sum of squared tap values. The window length is set to the cyclic-prefix length of the target system, and the default is 32 taps.

A run begins with a one-cycle start strobe that carries the response length. Taps arrive whenever the valid strobe is high, and gaps between them are allowed. A fixed number of cycles after the last tap, the block pulses `done_o`. With the pulse it presents three results: Δ, the energy inside the chosen window, and the energy of every tap outside it. A downstream stage divides the last two to form a shortened-SNR figure, which this block does not compute.

Top module: `peak_window_locator`

## Requirements
- R1: For the reported Δ, `win_energy_o` equals the sum of tap² over taps Δ through Δ+WIN_LEN-1, where tap index 0 is the first tap accepted after start.
- R2: Δ is the start position whose window energy is largest. When several windows tie, the smallest Δ is reported.
- R3: `out_energy_o` equals the sum of tap² over all accepted taps minus `win_energy_o`. For up to `MAX_TAPS` (256) taps of full-scale value -32768, no result wraps.
- R4: When the response length is below WIN_LEN, the block reports Δ = 0 and `out_energy_o` = 0, and `win_energy_o` is the total energy. A length exactly equal to WIN_LEN gives Δ = 0 and `out_energy_o` = 0.
- R5: A start strobe latches `len_i`. After that, exactly that many taps are taken, one for each cycle with `tap_valid_i` high. A valid tap seen while no run is active, or in the same cycle as a start, is ignored.
- R6: `done_o` is high for exactly one cycle. The rising edge of `done_o` comes on the third clock edge after the edge that accepts the last tap. The result outputs change only with `done_o` and hold between pulses.
- R7: A start strobe with a nonzero length abandons any run in progress, including results still in the pipeline. No `done_o` is produced for the abandoned run.
- R8: A start with `len_i` = 0 is ignored completely. A `len_i` above `MAX_TAPS` is treated as `MAX_TAPS`.
- R9: After reset, `done_o`, `delta_o`, `win_energy_o` and `out_energy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a new run |
| len_i | input | 9 | Response length, sampled with start_i |
| tap_valid_i | input | 1 | Qualifies tap_i |
| tap_i | input | 16 | Signed tap value |
| done_o | output | 1 | One-cycle result strobe |
| delta_o | output | 8 | Start position of the strongest window |
| win_energy_o | output | 40 | Energy inside the chosen window |
| out_energy_o | output | 40 | Energy outside the chosen window |

## Verification
Several properties are checked on every cycle:
- `done_o` never lasts more than one cycle.
- A restart always silences `done_o` on the next cycle.
- The best-so-far energy only grows within a run.
- The running window sum never exceeds the running total.
- Short responses report zero Δ and zero outside energy.
- A reported Δ always leaves room for a full window.

Other behaviours can only be shown by the bench's scenarios, which compare against a model on every clock:
- The argmax itself and the earliest-wins rule under ties.
- The exact three-edge latency.
- That idle taps and zero-length starts are ignored.
- Full-scale accumulation and length clamping.

// File: rtl/plw_pkg.sv
package plw_pkg;
  // Run control state of the locator
  typedef enum logic {
    PLW_IDLE = 1'b0,
    PLW_RUN  = 1'b1
  } plw_state_e;
endpackage

// File: rtl/plw_tap_square.sv
// Stage 1: register the squared tap together with its index and flags.
module plw_tap_square #(
  parameter int TAP_W = 16,
  parameter int IDX_W = 8,
  localparam int SQ_W = 2 * TAP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_v,
  input  logic                    in_last,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic signed [TAP_W-1:0] in_tap,
  output logic                    sq_v,
  output logic                    sq_last,
  output logic [IDX_W-1:0]        sq_idx,
  output logic [SQ_W-1:0]         sq_val
);
  logic signed [SQ_W-1:0] prod;
  assign prod = in_tap * in_tap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sq_v    <= 1'b0;
      sq_last <= 1'b0;
    end else begin
      sq_v    <= in_v;
      sq_last <= in_v && in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      sq_idx <= in_idx;
      sq_val <= prod;
    end
  end
endmodule

// File: rtl/plw_window_track.sv
// Stage 2: sliding window sum and running total, fed by a circular buffer of squares.
module plw_window_track #(
  parameter int SQ_W    = 32,
  parameter int ACC_W   = 40,
  parameter int IDX_W   = 8,
  parameter int WIN_LEN = 32,
  localparam int PTR_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rd_en,
  input  logic             sq_v,
  input  logic             sq_last,
  input  logic [IDX_W-1:0] sq_idx,
  input  logic [SQ_W-1:0]  sq_val,
  output logic [ACC_W-1:0] win_sum,
  output logic [ACC_W-1:0] total,
  output logic             cand_v,
  output logic [IDX_W-1:0] cand_start,
  output logic             trk_last
);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(WIN_LEN - 1);
  localparam logic [IDX_W:0]   FULL_AT = (IDX_W+1)'(WIN_LEN - 1);
  localparam logic [IDX_W:0]   DROP_AT = (IDX_W+1)'(WIN_LEN);
  localparam logic [IDX_W-1:0] BACK    = IDX_W'(WIN_LEN - 1);

  logic [SQ_W-1:0]  sq_mem [WIN_LEN];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [SQ_W-1:0]  leaving_q;
  logic [IDX_W:0]   idx_x;
  logic [ACC_W-1:0] drop_val;

  // pointer of the slot read for the tap in stage 0, reused for its write in stage 1
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (rd_en) begin
      rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      wr_ptr <= rd_ptr;
    end
  end

  // memory without reset so that block RAM can hold it
  always_ff @(posedge clk) begin
    if (rd_en) leaving_q <= sq_mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (sq_v) sq_mem[wr_ptr] <= sq_val;
  end

  assign idx_x    = {1'b0, sq_idx};
  assign drop_val = (idx_x >= DROP_AT) ? ACC_W'(leaving_q) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_sum  <= '0;
      total    <= '0;
      cand_v   <= 1'b0;
      trk_last <= 1'b0;
    end else begin
      cand_v   <= sq_v && (idx_x >= FULL_AT);
      trk_last <= sq_v && sq_last;
      if (sq_v) begin
        win_sum <= win_sum + ACC_W'(sq_val) - drop_val;
        total   <= total + ACC_W'(sq_val);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sq_v) cand_start <= sq_idx - BACK;
  end
endmodule

// File: rtl/plw_best_pick.sv
// Stage 3: keep the strongest window; strict compare keeps the earliest on ties.
module plw_best_pick #(
  parameter int ACC_W = 40,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cand_v,
  input  logic [IDX_W-1:0] cand_start,
  input  logic [ACC_W-1:0] cand_sum,
  input  logic             in_last,
  output logic [ACC_W-1:0] best_sum,
  output logic [IDX_W-1:0] best_start,
  output logic             pick_last
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_sum   <= '0;
      best_start <= '0;
      pick_last  <= 1'b0;
    end else begin
      pick_last <= in_last;
      if (cand_v && (cand_sum > best_sum)) begin
        best_sum   <= cand_sum;
        best_start <= cand_start;
      end
    end
  end
endmodule

// File: rtl/peak_window_locator.sv
module peak_window_locator
  import plw_pkg::*;
#(
  parameter int TAP_W    = 16,
  parameter int WIN_LEN  = 32,
  parameter int MAX_TAPS = 256,
  localparam int IDX_W   = $clog2(MAX_TAPS),
  localparam int LEN_W   = $clog2(MAX_TAPS + 1),
  localparam int SQ_W    = 2 * TAP_W,
  localparam int ACC_W   = SQ_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    tap_valid_i,
  input  logic signed [TAP_W-1:0] tap_i,
  output logic                    done_o,
  output logic [IDX_W-1:0]        delta_o,
  output logic [ACC_W-1:0]        win_energy_o,
  output logic [ACC_W-1:0]        out_energy_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_TAPS);
  localparam logic [LEN_W-1:0] WIN_L   = LEN_W'(WIN_LEN);

  plw_state_e       state;
  logic [LEN_W-1:0] len_q, len_eff;
  logic [IDX_W-1:0] idx_q;
  logic             short_q;
  logic             go, accept, last_tap;

  logic             sq_v, sq_last;
  logic [IDX_W-1:0] sq_idx;
  logic [SQ_W-1:0]  sq_val;
  logic [ACC_W-1:0] win_sum, total;
  logic             cand_v, trk_last;
  logic [IDX_W-1:0] cand_start;
  logic [ACC_W-1:0] best_sum;
  logic [IDX_W-1:0] best_start;
  logic             pick_last;

  assign go       = start_i && (len_i != '0);
  assign len_eff  = (len_i > LEN_CAP) ? LEN_CAP : len_i;
  assign accept   = (state == PLW_RUN) && tap_valid_i && !go;
  assign last_tap = accept && (LEN_W'(idx_q) == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PLW_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
      short_q <= 1'b0;
    end else if (go) begin
      state   <= PLW_RUN;
      len_q   <= len_eff;
      idx_q   <= '0;
      short_q <= (len_eff < WIN_L);
    end else if (accept) begin
      idx_q <= idx_q + 1'b1;
      if (last_tap) state <= PLW_IDLE;
    end
  end

  plw_tap_square #(.TAP_W(TAP_W), .IDX_W(IDX_W)) u_square (
    .clk     (clk),
    .rst     (rst),
    .clr     (go),
    .in_v    (accept),
    .in_last (last_tap),
    .in_idx  (idx_q),
    .in_tap  (tap_i),
    .sq_v    (sq_v),
    .sq_last (sq_last),
    .sq_idx  (sq_idx),
    .sq_val  (sq_val)
  );

  plw_window_track #(
    .SQ_W(SQ_W), .ACC_W(ACC_W), .IDX_W(IDX_W), .WIN_LEN(WIN_LEN)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .clr        (go),
    .rd_en      (accept),
    .sq_v       (sq_v),
    .sq_last    (sq_last),
    .sq_idx     (sq_idx),
    .sq_val     (sq_val),
    .win_sum    (win_sum),
    .total      (total),
    .cand_v     (cand_v),
    .cand_start (cand_start),
    .trk_last   (trk_last)
  );

  plw_best_pick #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst        (rst),
    .clr        (go),
    .cand_v     (cand_v),
    .cand_start (cand_start),
    .cand_sum   (win_sum),
    .in_last    (trk_last),
    .best_sum   (best_sum),
    .best_start (best_start),
    .pick_last  (pick_last)
  );

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      delta_o      <= '0;
      win_energy_o <= '0;
      out_energy_o <= '0;
    end else if (go) begin
      done_o <= 1'b0;
    end else begin
      done_o <= pick_last;
      if (pick_last) begin
        delta_o      <= short_q ? '0 : best_start;
        win_energy_o <= short_q ? total : best_sum;
        out_energy_o <= short_q ? '0 : (total - best_sum);
      end
    end
  end
endmodule

// File: rtl/plw_checker.sv
module plw_checker #(
  parameter int WIN_LEN = 32,
  parameter int IDX_W   = 8,
  parameter int LEN_W   = 9,
  parameter int ACC_W   = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             go,
  input logic             done_o,
  input logic [IDX_W-1:0] delta_o,
  input logic [ACC_W-1:0] out_energy_o,
  input logic             short_q,
  input logic [LEN_W-1:0] len_q,
  input logic [ACC_W-1:0] best_sum,
  input logic [ACC_W-1:0] win_sum,
  input logic [ACC_W-1:0] total
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    go |=> !done_o);

  p_short_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && short_q) |-> (delta_o == '0 && out_energy_o == '0));

  p_delta_room_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && !short_q) |-> ((int'(delta_o) + WIN_LEN) <= int'(len_q)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    total >= win_sum);

  p_best_grows_r1: assert property (@(posedge clk) disable iff (rst)
    !go |=> (best_sum >= $past(best_sum)));
endmodule

bind peak_window_locator plw_checker #(
  .WIN_LEN(WIN_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W), .ACC_W(ACC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .go           (go),
  .done_o       (done_o),
  .delta_o      (delta_o),
  .out_energy_o (out_energy_o),
  .short_q      (short_q),
  .len_q        (len_q),
  .best_sum     (best_sum),
  .win_sum      (win_sum),
  .total        (total)
);

// File: tb/peak_window_locator_bench.sv
`timescale 1ns/1ps
module peak_window_locator_bench;
  localparam int TAP_W = 16, WIN_LEN = 32, MAX_TAPS = 256;
  localparam int IDX_W = 8, LEN_W = 9, ACC_W = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, tap_valid_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic signed [TAP_W-1:0] tap_i = '0;
  logic done_o;
  logic [IDX_W-1:0] delta_o;
  logic [ACC_W-1:0] win_energy_o, out_energy_o;

  always #2 clk = ~clk;

  peak_window_locator #(.TAP_W(TAP_W), .WIN_LEN(WIN_LEN), .MAX_TAPS(MAX_TAPS)) u_peak_window_locator (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .tap_valid_i(tap_valid_i),
    .tap_i(tap_i), .done_o(done_o), .delta_o(delta_o),
    .win_energy_o(win_energy_o), .out_energy_o(out_energy_o));

  int n_vec = 0, n_bad = 0;
  string cur_req = "R9";

  // behavioural reference state
  bit     m_busy = 0;
  int     m_n = 0;
  int     m_taps[$];
  int     pend_cnt = 0;
  longint pend_d, pend_w, pend_o;
  bit     exp_done = 0;
  longint exp_d = 0, exp_w = 0, exp_o = 0;
  int     stim[$];

  task automatic chk(string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic void compute();
    longint sq[$];
    longint tot = 0, best = 0, s;
    int bd = 0;
    foreach (m_taps[i]) begin
      sq.push_back(longint'(m_taps[i]) * longint'(m_taps[i]));
      tot += sq[i];
    end
    if (m_n < WIN_LEN) begin
      pend_d = 0; pend_w = tot; pend_o = 0;
    end else begin
      for (int d = 0; d <= m_n - WIN_LEN; d++) begin
        s = 0;
        for (int k = 0; k < WIN_LEN; k++) s += sq[d+k];
        if (s > best) begin best = s; bd = d; end
      end
      pend_d = bd; pend_w = best; pend_o = tot - best;
    end
  endfunction

  task automatic model(bit s, int len, bit v, int tap);
    bit go = s && (len != 0);
    exp_done = 0;
    if (go) begin
      pend_cnt = 0;
      m_busy = 1;
      m_n = (len > MAX_TAPS) ? MAX_TAPS : len;
      m_taps.delete();
    end
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        exp_done = 1; exp_d = pend_d; exp_w = pend_w; exp_o = pend_o;
      end
    end
    if (!go && m_busy && v) begin
      m_taps.push_back(tap);
      if (m_taps.size() == m_n) begin
        m_busy = 0;
        compute();
        pend_cnt = 3;
      end
    end
  endtask

  task automatic compare();
    chk("done", longint'(done_o), longint'(exp_done));
    chk("delta", longint'(delta_o), exp_d);
    chk("win", longint'(win_energy_o), exp_w);
    chk("out", longint'(out_energy_o), exp_o);
  endtask

  task automatic cyc(bit s, int len, bit v, int tap);
    start_i = s; len_i = LEN_W'(len); tap_valid_i = v; tap_i = TAP_W'(tap);
    @(posedge clk);
    model(s, len, v, tap);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0);
  endtask

  // start, then feed stim with optional gaps, then drain
  task automatic feed(int len, bit gaps);
    cyc(1, len, 0, 0);
    foreach (stim[i]) begin
      if (gaps && ($urandom_range(3) == 0)) cyc(0, 0, 0, 12345);
      cyc(0, 0, 1, stim[i]);
    end
    idle(5);
  endtask

  function automatic void fill_const(int n, int val);
    stim.delete();
    for (int i = 0; i < n; i++) stim.push_back(val);
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    cur_req = "R9";
    compare();
    rst = 1'b0;
    idle(3);

    // R1: random response with gaps in the valid strobe (R5)
    cur_req = "R1";
    stim.delete();
    for (int i = 0; i < 80; i++) stim.push_back($urandom_range(4000) - 2000);
    feed(80, 1);

    // R2: single impulse at tap 40, earliest covering start is 9
    cur_req = "R2";
    fill_const(100, 0);
    stim[40] = 1000;
    feed(100, 0);
    // R2: flat response, every window ties, earliest (0) wins
    fill_const(64, -77);
    feed(64, 0);
    // R2: energy cluster late in the response
    fill_const(120, 3);
    for (int i = 70; i < 90; i++) stim[i] = 900 - i;
    feed(120, 1);

    // R3: full-scale taps over the maximum length
    cur_req = "R3";
    fill_const(256, -32768);
    feed(256, 0);

    // R4: short response and exact window length
    cur_req = "R4";
    stim.delete();
    for (int i = 0; i < 10; i++) stim.push_back(i * 100 - 450);
    feed(10, 0);
    fill_const(32, 500);
    stim[5] = -20000;
    feed(32, 0);

    // R5: taps while idle are ignored; outputs hold
    cur_req = "R5";
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 30000);
    // tap in the start cycle is not counted
    stim.delete();
    for (int i = 0; i < 40; i++) stim.push_back(i);
    start_i = 1; len_i = 40; tap_valid_i = 1; tap_i = 16'sd9999;
    @(posedge clk); model(1, 40, 1, 9999); @(negedge clk); compare();
    foreach (stim[i]) cyc(0, 0, 1, stim[i]);
    idle(5);

    // R7: restart in the middle of a run
    cur_req = "R7";
    cyc(1, 60, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 5000);
    stim.delete();
    for (int i = 0; i < 40; i++) stim.push_back((i % 7) * 300);
    feed(40, 0);
    // R7: restart on the edge where done would rise
    cyc(1, 33, 0, 0);
    for (int i = 0; i < 33; i++) cyc(0, 0, 1, i * 11);
    idle(2);
    cyc(1, 5, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 7);
    idle(5);

    // R8: zero length start ignored, oversize length clamped
    cur_req = "R8";
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1234);
    fill_const(300, 100);
    for (int i = 200; i < 240; i++) stim[i] = 2000;
    feed(300, 0);

    // R6: back-to-back runs, start right after the done pulse
    cur_req = "R6";
    fill_const(50, 10);
    stim[45] = 3000;
    cyc(1, 50, 0, 0);
    foreach (stim[i]) cyc(0, 0, 1, stim[i]);
    idle(3);
    fill_const(50, -10);
    feed(50, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog: got timeout expected completion", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule